// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind the serial shifter of an I2C target. It watches the bytes that the shifter delivers after each START condition and decides whether this device is being addressed. It does not touch the bus wires. It tells the shifter whether to pull SDA low on the ninth clock, and it reports the transfer direction to the logic that moves the data.

The own address is set by configuration inputs. In short mode the address is 7 bits and fits in one byte. In long mode it is 10 bits and takes two bytes: a header byte and then a low byte. A header byte is the tag `11110`, then address bits 9:8, then the R/W bit in bit 0. A zero first byte is the general call. Answering the general call can be turned on or off. After a full 10-bit write match, a repeated START followed by the read header resumes the same target in transmit direction.

All outputs are registered. Each output changes in the cycle after the strobe that causes it.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `addr_match`, `gc_match`, `ack_en`, `dir_tx` and `match_evt` are all 0.
- R2: In short mode (`cfg_ten_bit`=0), suppose the first byte after START is non-zero and its bits 7:1 equal `cfg_own_addr[6:0]`. Then the next cycle shows `addr_match`=1, `ack_en`=1 and `dir_tx` equal to byte bit 0 (1 = read, the target transmits).
- R3: A first byte that matches nothing gives `ack_en`=0 and no flags. Every further byte is ignored until the next START, even a byte that would match.
- R4: In long mode, a header byte with matching bits 2:1 and bit 0 = 0 gives `ack_en`=1 with `addr_match`=0. Next, a low byte equal to `cfg_own_addr[7:0]` gives `addr_match`=1, `ack_en`=1 and `dir_tx`=0.
- R5: In long mode, if the low byte after an accepted header differs from `cfg_own_addr[7:0]`, `ack_en` drops to 0 and no match is reported.
- R6: A repeated START, then a read header (bit 0 = 1), after a complete 10-bit match gives `addr_match`=1, `dir_tx`=1 and `ack_en`=1. A read header with no prior 10-bit match in this transfer is not acknowledged.
- R7: A zero first byte with `cfg_gc_en`=1 gives `gc_match`=1, `ack_en`=1 and `addr_match`=0. With `cfg_gc_en`=0 it is not acknowledged. A zero byte never counts as the own address.
- R8: STOP clears every output and forgets a 10-bit match. STOP wins over a START or a byte strobe in the same cycle.
- R9: START clears `addr_match`, `gc_match`, `ack_en` and `dir_tx`. A byte strobe in the same cycle as START is discarded.
- R10: Once matched, later data bytes leave `addr_match`, `gc_match`, `ack_en` and `dir_tx` unchanged.
- R11: `match_evt` is a one-cycle pulse. It appears exactly in the cycle in which a match is newly declared (R2, R4 low byte, R6, R7), and `ack_en` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_own_addr | input | 10 | Own address (bits 6:0 used in short mode) |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_gc_en | input | 1 | 1 answers the general call |
| start_evt | input | 1 | START or repeated START seen (one cycle) |
| stop_evt | input | 1 | STOP seen (one cycle) |
| byte_valid | input | 1 | Received byte is complete (one cycle) |
| byte_data | input | 8 | Received byte, bit 7 first on the wire |
| addr_match | output | 1 | Own address matched |
| gc_match | output | 1 | General call matched |
| ack_en | output | 1 | Drive ACK on the ninth clock of this byte |
| dir_tx | output | 1 | 1 = target transmits (read) |
| match_evt | output | 1 | One-cycle pulse on a new match |

## Verification
The bus events can collide: a START or a STOP can arrive in the same cycle as a byte strobe, and a START can arrive together with a STOP. The bench drives these coincidences in directed cases, for example STOP + START + matching byte, and START + matching byte. It also drives them at random inside random transfers. A reference model in the bench applies the priority order STOP, then START, then byte, and every output is compared with that model each cycle.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;
  typedef enum logic [2:0] {
    AR_OFF  = 3'd0,
    AR_ADDR = 3'd1,
    AR_HDR  = 3'd2,
    AR_DATA = 3'd3,
    AR_SKIP = 3'd4
  } ar_state_e;

  localparam int          AR_TAG_W   = 5;
  localparam logic [4:0]  AR_HDR_TAG = 5'b11110;
endpackage

// File: rtl/i2c_ar_cmp.sv
module i2c_ar_cmp
  import i2c_ar_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int OWN_W      = 10,
  parameter bit GC_SUPPORT = 1'b1
) (
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [OWN_W-1:0]  own_addr,
  output logic              hit_short,
  output logic              hit_gc,
  output logic              hit_hdr,
  output logic              hit_lo,
  output logic              rw_bit
);
  localparam int SHORT_W = BYTE_W - 1;
  localparam int HI_W    = OWN_W - BYTE_W;

  logic is_zero;

  assign is_zero   = (byte_data == '0);
  assign rw_bit    = byte_data[0];
  assign hit_short = !is_zero && (byte_data[BYTE_W-1:1] == own_addr[SHORT_W-1:0]);
  assign hit_hdr   = (byte_data[BYTE_W-1 -: AR_TAG_W] == AR_HDR_TAG) &&
                     (byte_data[HI_W:1] == own_addr[OWN_W-1:BYTE_W]);
  assign hit_lo    = (byte_data == own_addr[BYTE_W-1:0]);

  generate
    if (GC_SUPPORT) begin : g_gc
      assign hit_gc = is_zero;
    end else begin : g_no_gc
      assign hit_gc = 1'b0;
    end
  endgenerate

  always_comb begin
    assert (!(hit_gc && hit_short)) else $error("assert_zero_not_own_R7");
  end
endmodule

// File: rtl/i2c_ar_fsm.sv
module i2c_ar_fsm
  import i2c_ar_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic byte_valid,
  input  logic ten_bit,
  input  logic gc_en,
  input  logic hit_short,
  input  logic hit_gc,
  input  logic hit_hdr,
  input  logic hit_lo,
  input  logic rw_bit,
  output logic addr_match,
  output logic gc_match,
  output logic ack_en,
  output logic dir_tx,
  output logic match_evt
);
  ar_state_e state;
  logic      ten_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= AR_OFF;
      ten_done   <= 1'b0;
      addr_match <= 1'b0;
      gc_match   <= 1'b0;
      ack_en     <= 1'b0;
      dir_tx     <= 1'b0;
      match_evt  <= 1'b0;
    end else begin
      match_evt <= 1'b0;
      if (stop_evt) begin
        state      <= AR_OFF;
        ten_done   <= 1'b0;
        addr_match <= 1'b0;
        gc_match   <= 1'b0;
        ack_en     <= 1'b0;
        dir_tx     <= 1'b0;
      end else if (start_evt) begin
        state      <= AR_ADDR;
        addr_match <= 1'b0;
        gc_match   <= 1'b0;
        ack_en     <= 1'b0;
        dir_tx     <= 1'b0;
      end else if (byte_valid) begin
        case (state)
          AR_ADDR: begin
            if (gc_en && hit_gc) begin
              gc_match  <= 1'b1;
              ack_en    <= 1'b1;
              match_evt <= 1'b1;
              ten_done  <= 1'b0;
              state     <= AR_DATA;
            end else if (ten_bit && hit_hdr && !rw_bit) begin
              ack_en   <= 1'b1;
              ten_done <= 1'b0;
              state    <= AR_HDR;
            end else if (ten_bit && hit_hdr && rw_bit && ten_done) begin
              addr_match <= 1'b1;
              ack_en     <= 1'b1;
              dir_tx     <= 1'b1;
              match_evt  <= 1'b1;
              state      <= AR_DATA;
            end else if (!ten_bit && hit_short) begin
              addr_match <= 1'b1;
              ack_en     <= 1'b1;
              dir_tx     <= rw_bit;
              match_evt  <= 1'b1;
              ten_done   <= 1'b0;
              state      <= AR_DATA;
            end else begin
              ack_en   <= 1'b0;
              ten_done <= 1'b0;
              state    <= AR_SKIP;
            end
          end
          AR_HDR: begin
            if (hit_lo) begin
              addr_match <= 1'b1;
              ack_en     <= 1'b1;
              dir_tx     <= 1'b0;
              match_evt  <= 1'b1;
              ten_done   <= 1'b1;
              state      <= AR_DATA;
            end else begin
              ack_en <= 1'b0;
              state  <= AR_SKIP;
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(addr_match && gc_match));

  assert_evt_acked_R11: assert property (@(posedge clk) disable iff (rst)
    match_evt |-> ack_en);

  assert_evt_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    match_evt |=> !match_evt);

  assert_stop_clear_R8: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (!ack_en && !addr_match && !gc_match && !dir_tx && !ten_done));

  assert_start_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !stop_evt) |=> (!ack_en && !addr_match && !gc_match && !match_evt));

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (state == AR_DATA && !start_evt && !stop_evt) |=>
      ($stable(addr_match) && $stable(gc_match) && $stable(ack_en) && $stable(dir_tx)));

  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (state == AR_SKIP && !start_evt && !stop_evt) |=> (!ack_en && !match_evt));
endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer #(
  parameter int BYTE_W     = 8,
  parameter int OWN_W      = 10,
  parameter bit GC_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OWN_W-1:0]  cfg_own_addr,
  input  logic              cfg_ten_bit,
  input  logic              cfg_gc_en,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              addr_match,
  output logic              gc_match,
  output logic              ack_en,
  output logic              dir_tx,
  output logic              match_evt
);
  logic hit_short, hit_gc, hit_hdr, hit_lo, rw_bit;

  i2c_ar_cmp #(
    .BYTE_W    (BYTE_W),
    .OWN_W     (OWN_W),
    .GC_SUPPORT(GC_SUPPORT)
  ) u_cmp (
    .byte_data (byte_data),
    .own_addr  (cfg_own_addr),
    .hit_short (hit_short),
    .hit_gc    (hit_gc),
    .hit_hdr   (hit_hdr),
    .hit_lo    (hit_lo),
    .rw_bit    (rw_bit)
  );

  i2c_ar_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .byte_valid (byte_valid),
    .ten_bit    (cfg_ten_bit),
    .gc_en      (cfg_gc_en),
    .hit_short  (hit_short),
    .hit_gc     (hit_gc),
    .hit_hdr    (hit_hdr),
    .hit_lo     (hit_lo),
    .rw_bit     (rw_bit),
    .addr_match (addr_match),
    .gc_match   (gc_match),
    .ack_en     (ack_en),
    .dir_tx     (dir_tx),
    .match_evt  (match_evt)
  );
endmodule

// File: tb/i2c_addr_recognizer_tb.sv
module i2c_addr_recognizer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] own = '0;
  logic       ten = 1'b0;
  logic       gce = 1'b0;
  logic       st = 1'b0, sp = 1'b0, bv = 1'b0;
  logic [7:0] bd = '0;
  logic       o_m, o_g, o_a, o_d, o_v;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  i2c_addr_recognizer u_dut (
    .clk(clk), .rst(rst), .cfg_own_addr(own), .cfg_ten_bit(ten), .cfg_gc_en(gce),
    .start_evt(st), .stop_evt(sp), .byte_valid(bv), .byte_data(bd),
    .addr_match(o_m), .gc_match(o_g), .ack_en(o_a), .dir_tx(o_d), .match_evt(o_v)
  );

  int    ms = 0;
  bit    mten = 0;
  bit    e_m = 0, e_g = 0, e_a = 0, e_d = 0, e_v = 0;
  string tag = "R1";

  task automatic chk(string t, string nm, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", t, nm, act, exp);
    end
  endtask

  task automatic model(bit s, bit p, bit v, logic [7:0] b);
    e_v = 0;
    if (p) begin
      ms = 0; mten = 0; e_m = 0; e_g = 0; e_a = 0; e_d = 0; tag = "R8";
    end else if (s) begin
      ms = 1; e_m = 0; e_g = 0; e_a = 0; e_d = 0; tag = "R9";
    end else if (v) begin
      case (ms)
        1: begin
          if (gce && b == 8'h00) begin
            e_g = 1; e_a = 1; e_v = 1; ms = 3; mten = 0; tag = "R7";
          end else if (ten && b[7:3] == 5'b11110 && b[2:1] == own[9:8] && !b[0]) begin
            e_a = 1; ms = 2; mten = 0; tag = "R4";
          end else if (ten && b[7:3] == 5'b11110 && b[2:1] == own[9:8] && mten) begin
            e_m = 1; e_a = 1; e_d = 1; e_v = 1; ms = 3; tag = "R6";
          end else if (!ten && b != 8'h00 && b[7:1] == own[6:0]) begin
            e_m = 1; e_a = 1; e_d = b[0]; e_v = 1; ms = 3; mten = 0; tag = "R2";
          end else begin
            e_a = 0; ms = 4; mten = 0; tag = "R3";
          end
        end
        2: begin
          if (b == own[7:0]) begin
            e_m = 1; e_a = 1; e_d = 0; e_v = 1; ms = 3; mten = 1; tag = "R4";
          end else begin
            e_a = 0; ms = 4; tag = "R5";
          end
        end
        3: tag = "R10";
        default: tag = "R3";
      endcase
    end else tag = "R11";
  endtask

  task automatic cyc(bit s, bit p, bit v, logic [7:0] b);
    st = s; sp = p; bv = v; bd = b;
    @(negedge clk);
    st = 0; sp = 0; bv = 0;
    model(s, p, v, b);
    chk(tag, "addr_match", o_m, e_m);
    chk(tag, "gc_match",   o_g, e_g);
    chk(tag, "ack_en",     o_a, e_a);
    chk(tag, "dir_tx",     o_d, e_d);
    chk((e_v || o_v) ? "R11" : tag, "match_evt", o_v, e_v);
  endtask

  task automatic cfg(bit t, bit g, logic [9:0] a);
    cyc(0, 1, 0, 8'h00);
    ten = t; gce = g; own = a;
  endtask

  function automatic logic [7:0] hdr(logic [9:0] a, bit rd);
    return {5'b11110, a[9:8], rd};
  endfunction

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5821));
    @(negedge clk);
    chk("R1", "addr_match", o_m, 0);
    chk("R1", "ack_en", o_a, 0);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "gc_match", o_g, 0);
    chk("R1", "dir_tx", o_d, 0);
    chk("R1", "match_evt", o_v, 0);

    // R2: short write and read
    cfg(0, 0, 10'h05A);
    cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'hB4); cyc(0, 0, 1, 8'h33); cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'hB5); cyc(0, 0, 1, 8'hFF);
    // R3: miss, then matching byte ignored
    cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'hB6); cyc(0, 0, 1, 8'hB4);
    // R7: general call on, then off
    cfg(0, 1, 10'h05A);
    cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h00); cyc(0, 0, 1, 8'h12);
    cfg(0, 0, 10'h000);
    cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h00);
    // R4 / R6: 10-bit write then resume read
    cfg(1, 1, 10'h2C7);
    cyc(1, 0, 0, 0); cyc(0, 0, 1, hdr(10'h2C7, 0)); cyc(0, 0, 1, 8'hC7); cyc(0, 0, 1, 8'h01);
    cyc(1, 0, 0, 0); cyc(0, 0, 1, hdr(10'h2C7, 1)); cyc(0, 0, 1, 8'h44);
    // R5: wrong low byte
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0); cyc(0, 0, 1, hdr(10'h2C7, 0)); cyc(0, 0, 1, 8'hC6);
    // R6: read header without earlier match
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0); cyc(0, 0, 1, hdr(10'h2C7, 1));
    // R8: STOP forgets 10-bit match; STOP beats START + byte
    cyc(1, 0, 0, 0); cyc(0, 0, 1, hdr(10'h2C7, 0)); cyc(0, 0, 1, 8'hC7);
    cyc(1, 1, 1, hdr(10'h2C7, 1));
    cyc(1, 0, 0, 0); cyc(0, 0, 1, hdr(10'h2C7, 1));
    // R9: START with same-cycle byte discards byte
    cfg(0, 0, 10'h05A);
    cyc(1, 0, 1, 8'hB4); cyc(0, 0, 1, 8'hB4);
    cyc(0, 0, 1, 8'hB4); cyc(1, 0, 1, 8'hB4);

    // random transfers
    for (int ep = 0; ep < 400; ep++) begin
      logic [9:0] a;
      a = 10'($urandom);
      cfg(1'($urandom), 1'($urandom), a);
      cyc(1, 0, 0, 0);
      for (int k = 0; k < 6; k++) begin
        int sel;
        logic [7:0] b;
        sel = $urandom_range(0, 9);
        case (sel)
          0, 1:    b = {a[6:0], 1'($urandom)};
          2, 3:    b = hdr(a, 0);
          4:       b = hdr(a, 1);
          5:       b = a[7:0];
          6:       b = 8'h00;
          default: b = 8'($urandom);
        endcase
        if ($urandom_range(0, 9) == 0)
          cyc(1, $urandom_range(0, 3) == 0, 1, b);
        else if ($urandom_range(0, 7) == 0)
          cyc(1, 0, 0, 0);
        else
          cyc(0, 0, $urandom_range(0, 5) != 0, b);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule